// File: doc/BRIEF.md
# Three-Stage Split-Operand Integer Multiplier

This block computes the four integer multiply operations of a 32-bit RISC processor's multiply extension: the low word of the product, and the high word with both operands signed, with the first signed and the second unsigned, or with both unsigned. Each operand is cut into a 16-bit lower half and an upper half. The halves are widened to 17 bits so that every partial product is a 17x17 signed multiply, the shape a typical FPGA DSP slice provides. Exactly four such products make up the 64-bit result.

The work is spread over three registered stages. Stage one holds the four partial products. Stage two holds the sum of the two middle terms, which carry a weight of 2^16. Stage three adds all terms into the 64-bit product and registers the selected word. An operation can be accepted on every cycle. A valid bit travels alongside the data. A single enable input freezes all three stages at once, so the surrounding pipeline can stall the unit without losing work in flight.

Top module: `mulsplit_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all stages are cleared, so that `out_valid` reads 0 and `out_data` reads 0 afterwards.
- R2: An operation taken with `in_valid`=1 at an enabled edge produces `out_valid`=1 after exactly three enabled edges (counting that edge), and not earlier.
- R3: Opcode 2'b00 returns bits 31:0 of the product of `in_a` and `in_b`; this word does not depend on operand signedness.
- R4: Opcode 2'b01 returns bits 63:32 of the product with both operands taken as two's-complement signed.
- R5: Opcode 2'b10 returns bits 63:32 of the product with `in_a` signed and `in_b` unsigned.
- R6: Opcode 2'b11 returns bits 63:32 of the product with both operands unsigned.
- R7: A new operation can be taken on every enabled cycle; back-to-back operations come out on consecutive cycles, in issue order, each with its own correct result.
- R8: While `en` is low, no stage changes: `out_valid` and `out_data` hold, inputs presented during that time are ignored, and work in flight resumes with correct results once `en` returns high.
- R9: A cycle taken with `in_valid`=0 yields `out_valid`=0 three enabled edges later, so gaps in the issue stream show up as gaps at the output.
- R10: Extreme operands (most negative value, all ones, mixed signs, and carries across the 16-bit boundary) give exact results under every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance enable; low freezes every stage |
| in_valid | input | 1 | Marks the operands and opcode as a real operation |
| in_op | input | 2 | Operation: 00 low word, 01 high signed x signed, 10 high signed x unsigned, 11 high unsigned x unsigned |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result word is valid |
| out_data | output | 32 | Selected 32-bit word of the product |

## Verification
The hardest case to reach from the ports is a stall that lands while several operations are in flight at different stages. The frozen state must then hold, and the inputs that change during the stall must have no effect. The bench issues an operation, drops `en` with new operands and a raised `in_valid` on the inputs, holds the stall for several cycles, and checks that the result comes out with the right value and at the right point. A stall is also applied while a result sits at the output. High-word signedness errors only show up with operands whose upper halves carry the sign bit and whose middle terms carry across bit 16, so the directed tests combine such operands with every opcode, and a stream of generated operands runs back to back.

// File: rtl/mulsplit_pkg.sv
`timescale 1ns/100ps
// Shared definitions for the split-operand multiplier.
// Assumes the opcode encoding used by the processor decoder.
package mulsplit_pkg;
    typedef enum logic [1:0] {
        OP_LOWORD = 2'b00,
        OP_HI_SS  = 2'b01,
        OP_HI_SU  = 2'b10,
        OP_HI_UU  = 2'b11
    } mul_op_e;

    // Whether the first operand's upper half is sign-extended.
    function automatic logic a_is_signed(input mul_op_e op);
        return (op == OP_HI_SS) || (op == OP_HI_SU);
    endfunction

    // Whether the second operand's upper half is sign-extended.
    function automatic logic b_is_signed(input mul_op_e op);
        return (op == OP_HI_SS);
    endfunction
endpackage

// File: rtl/mulsplit_halves.sv
`timescale 1ns/100ps
// Splits one operand into two 17-bit halves for a signed 17x17 multiplier.
// The lower half is always zero-extended. The upper half is sign-extended
// only when the operand is treated as signed. Purely combinational.
module mulsplit_halves #(
    parameter int XLEN = 32,
    localparam int HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] opnd,
    input  logic            is_signed,
    output logic [HALF:0]   lo,
    output logic [HALF:0]   hi
);
    // Widen both halves by one bit.
    always_comb begin
        lo = {1'b0, opnd[HALF-1:0]};
        hi = {is_signed & opnd[XLEN-1], opnd[XLEN-1:HALF]};
    end
endmodule

// File: rtl/mulsplit_prod_stage.sv
`timescale 1ns/100ps
// Stage 1: forms and registers the four 17x17 signed partial products.
// Slot 0 = lo*lo, slot 1 = a_lo*b_hi, slot 2 = a_hi*b_lo, slot 3 = hi*hi.
// Assumes the halves come from mulsplit_halves; en freezes the stage.
module mulsplit_prod_stage #(
    parameter int XLEN = 32,
    localparam int HALF = XLEN / 2,
    localparam int PW   = HALF + 1,
    localparam int PW2  = 2 * PW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 in_valid,
    input  logic [1:0]           in_op,
    input  logic [PW-1:0]        a_lo,
    input  logic [PW-1:0]        a_hi,
    input  logic [PW-1:0]        b_lo,
    input  logic [PW-1:0]        b_hi,
    output logic [3:0][PW2-1:0]  prods,
    output logic                 s1_valid,
    output logic [1:0]           s1_op
);
    for (genvar i = 0; i < 4; i++) begin : g_prod
        localparam bit TAKE_AHI = (i / 2) == 1;
        localparam bit TAKE_BHI = (i % 2) == 1;
        logic [PW-1:0]  x_sel, y_sel;
        logic [PW2-1:0] p_q;

        // Choose the operand halves for this slot.
        always_comb begin
            x_sel = TAKE_AHI ? a_hi : a_lo;
            y_sel = TAKE_BHI ? b_hi : b_lo;
        end

        // Register the sign-extended product of the selected halves.
        always_ff @(posedge clk) begin
            if (!rst_n)
                p_q <= '0;
            else if (en)
                p_q <= $signed({{PW{x_sel[PW-1]}}, x_sel}) *
                       $signed({{PW{y_sel[PW-1]}}, y_sel});
        end

        assign prods[i] = p_q;
    end

    // Carry valid and opcode alongside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= 2'b00;
        end else if (en) begin
            s1_valid <= in_valid;
            s1_op    <= in_op;
        end
    end
endmodule

// File: rtl/mulsplit_sum_stage.sv
`timescale 1ns/100ps
// Stages 2 and 3: stage 2 adds the two middle terms and keeps the outer
// terms; stage 3 forms low + (mid << HALF) + (high << 2*HALF) and registers
// the word the opcode selects. en freezes both stages.
module mulsplit_sum_stage
    import mulsplit_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int HALF = XLEN / 2,
    localparam int PW   = HALF + 1,
    localparam int PW2  = 2 * PW,
    localparam int CW   = PW2 + 1,
    localparam int FW   = 2 * XLEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [3:0][PW2-1:0]  prods,
    input  logic                 s1_valid,
    input  logic [1:0]           s1_op,
    output logic                 out_valid,
    output logic [XLEN-1:0]      out_data
);
    logic [2*HALF-1:0] low_q;
    logic [CW-1:0]     mid_q;
    logic [PW2-1:0]    high_q;
    logic              s2_valid;
    logic [1:0]        s2_op;
    logic [CW-1:0]     mid_sum;
    logic [FW-1:0]     full;

    // Sum the two middle terms with sign extension by one bit.
    always_comb begin
        mid_sum = {prods[1][PW2-1], prods[1]} + {prods[2][PW2-1], prods[2]};
    end

    // Stage 2 registers: low term, middle sum, high term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q    <= '0;
            mid_q    <= '0;
            high_q   <= '0;
            s2_valid <= 1'b0;
            s2_op    <= 2'b00;
        end else if (en) begin
            low_q    <= prods[0][2*HALF-1:0];
            mid_q    <= mid_sum;
            high_q   <= prods[3];
            s2_valid <= s1_valid;
            s2_op    <= s1_op;
        end
    end

    // Assemble the full-width product modulo 2^FW.
    always_comb begin
        full = {{(FW-2*HALF){1'b0}}, low_q}
             + ({{(FW-CW){mid_q[CW-1]}}, mid_q} << HALF)
             + ({{(FW-PW2){high_q[PW2-1]}}, high_q} << (2*HALF));
    end

    // Stage 3 registers: the selected word and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (en) begin
            out_valid <= s2_valid;
            out_data  <= (mul_op_e'(s2_op) == OP_LOWORD) ? full[XLEN-1:0]
                                                          : full[FW-1:XLEN];
        end
    end

    // The low word's bottom bits come straight from the lo*lo term.
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mul_op_e'(s2_op) == OP_LOWORD) |=> (out_data[HALF-1:0] == $past(low_q[HALF-1:0]))); // R3
endmodule

// File: rtl/mulsplit_top.sv
`timescale 1ns/100ps
// Three-stage multiplier built from four 17x17 signed partial products.
// One operation per enabled cycle; result three enabled edges later.
// Assumes en low stalls the whole unit and that reset is synchronous.
module mulsplit_top
    import mulsplit_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int HALF = XLEN / 2,
    localparam int PW   = HALF + 1,
    localparam int PW2  = 2 * PW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    output logic            out_valid,
    output logic [XLEN-1:0] out_data
);
    logic [1:0][PW-1:0] lo_h, hi_h;
    logic [1:0]         sgn;
    logic [1:0][XLEN-1:0] opnds;
    logic [3:0][PW2-1:0] prods;
    logic               s1_valid;
    logic [1:0]         s1_op;

    // Signedness of each operand from the opcode.
    always_comb begin
        sgn[0]   = a_is_signed(mul_op_e'(in_op));
        sgn[1]   = b_is_signed(mul_op_e'(in_op));
        opnds[0] = in_a;
        opnds[1] = in_b;
    end

    for (genvar k = 0; k < 2; k++) begin : g_split
        mulsplit_halves #(.XLEN(XLEN)) u_split (
            .opnd      (opnds[k]),
            .is_signed (sgn[k]),
            .lo        (lo_h[k]),
            .hi        (hi_h[k])
        );
    end

    mulsplit_prod_stage #(.XLEN(XLEN)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_valid (in_valid),
        .in_op    (in_op),
        .a_lo     (lo_h[0]),
        .a_hi     (hi_h[0]),
        .b_lo     (lo_h[1]),
        .b_hi     (hi_h[1]),
        .prods    (prods),
        .s1_valid (s1_valid),
        .s1_op    (s1_op)
    );

    mulsplit_sum_stage #(.XLEN(XLEN)) u_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .prods     (prods),
        .s1_valid  (s1_valid),
        .s1_op     (s1_op),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(en, 2) && $past(rst_n) && $past(rst_n, 2) && $past(in_valid, 2))
        |=> out_valid); // R2

    AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(en, 2) && $past(rst_n) && $past(rst_n, 2) && !$past(in_valid, 2))
        |=> !out_valid); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(out_valid) && $stable(out_data))); // R8

    AST_S1_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_valid) |=> s1_valid); // R7
endmodule

// File: tb/sim_mulsplit_top.sv
`timescale 1ns/100ps
// Directed bench for mulsplit_top: one task per scenario, each checking itself.
module sim_mulsplit_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rng = 32'h1BADF00D;

    always #2.5 clk = ~clk;

    mulsplit_top u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
        .in_op(in_op), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Reference model written from the requirements.
    function automatic logic [31:0] ref_mul(input logic [1:0] op,
                                            input logic [31:0] a,
                                            input logic [31:0] b);
        logic signed [65:0] xa, xb, p;
        logic sa, sb;
        sa = (op == 2'b01) || (op == 2'b10);
        sb = (op == 2'b01);
        xa = sa ? {{34{a[31]}}, a} : {34'b0, a};
        xb = sb ? {{34{b[31]}}, b} : {34'b0, b};
        p  = xa * xb;
        return (op == 2'b00) ? p[31:0] : p[63:32];
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check(out_data == 32'h0, "R1 out_data in reset", out_data, 32'h0);
        rst_n = 1'b1;
    endtask

    // Single operation; checks exact latency and value.
    task automatic run_one(input logic [1:0] op, input logic [31:0] a,
                           input logic [31:0] b, input string req);
        logic [31:0] e;
        e = ref_mul(op, a, b);
        @(negedge clk);
        en = 1'b1; in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0; in_a = ~a; in_b = ~b;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 early valid", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        check(out_valid == 1'b1, "R2 valid after three edges", {31'b0, out_valid}, 32'h1);
        check(out_data == e, req, out_data, e);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 idle after result", {31'b0, out_valid}, 32'h0);
    endtask

    // Each opcode over extreme operand pairs.
    task automatic test_corners();
        logic [31:0] av [8] = '{32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h12345678,
                                32'h00018000, 32'h00000000, 32'hFFFF0001, 32'h8000FFFF};
        logic [31:0] bv [8] = '{32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h9ABCDEF0,
                                32'hFFFF8000, 32'hDEADBEEF, 32'h0000FFFF, 32'h7FFF0001};
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 8; k++) begin
                case (op)
                    0: run_one(2'(op), av[k], bv[k], "R3 low word");
                    1: run_one(2'(op), av[k], bv[k], "R4 high signed x signed");
                    2: run_one(2'(op), av[k], bv[k], "R5 high signed x unsigned");
                    default: run_one(2'(op), av[k], bv[k], "R6 high unsigned x unsigned");
                endcase
            end
        end
        run_one(2'b01, 32'h80000000, 32'h80000000, "R10 min x min signed high");
        run_one(2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, "R10 -1 x max unsigned high");
        run_one(2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF, "R10 max x max unsigned high");
    endtask

    // Back-to-back stream with a bubble at slot 7.
    task automatic test_stream();
        localparam int N = 24;
        logic [31:0] ea [N];
        logic        ev [N];
        for (int i = 0; i < N + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check(out_valid == ev[i-3], "R7 R9 stream valid", {31'b0, out_valid}, {31'b0, ev[i-3]});
                if (ev[i-3])
                    check(out_data == ea[i-3], "R7 stream data", out_data, ea[i-3]);
            end
            if (i < N) begin
                rng = next_rng(rng); in_a = rng;
                rng = next_rng(rng); in_b = rng;
                in_op = rng[9:8];
                in_valid = (i != 7);
                ev[i] = in_valid;
                ea[i] = ref_mul(in_op, in_a, in_b);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    // Stall with work in flight and with a result at the output.
    task automatic test_stall();
        logic [31:0] e, e2, held;
        e  = ref_mul(2'b10, 32'hF0F0F0F0, 32'h87654321);
        e2 = ref_mul(2'b01, 32'h00007FFF, 32'hFFFF0000);
        @(negedge clk);
        en = 1'b1; in_valid = 1'b1; in_op = 2'b10; in_a = 32'hF0F0F0F0; in_b = 32'h87654321;
        @(negedge clk);
        in_op = 2'b01; in_a = 32'h00007FFF; in_b = 32'hFFFF0000;
        @(negedge clk);
        en = 1'b0; in_valid = 1'b1; in_op = 2'b11; in_a = 32'hFFFFFFFF; in_b = 32'h12345678;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R8 no output during stall", {31'b0, out_valid}, 32'h0);
        end
        en = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b1, "R8 first result after stall", {31'b0, out_valid}, 32'h1);
        check(out_data == e, "R8 first value after stall", out_data, e);
        en = 1'b0;
        held = out_data;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(out_data == held && out_valid, "R8 output held", out_data, held);
        end
        en = 1'b1;
        @(negedge clk);
        check(out_data == e2 && out_valid, "R8 second value after stall", out_data, e2);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 stalled inputs ignored", {31'b0, out_valid}, 32'h0);
    endtask

    // Reset in the middle of work clears everything.
    task automatic test_mid_reset();
        @(negedge clk);
        en = 1'b1; in_valid = 1'b1; in_op = 2'b11; in_a = 32'hAAAA5555; in_b = 32'h5555AAAA;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == 32'h0, "R1 mid-run reset", out_data, 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 nothing survives reset", {31'b0, out_valid}, 32'h0);
        end
    endtask

    initial begin
        do_reset();
        test_corners();
        test_stream();
        test_stall();
        test_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule